// File: doc/BRIEF.md
# Onboard Time Counter with Tick Resynchronisation

This block keeps the onboard time as a coarse seconds word and a fine sub-second count. Between external time ticks it counts on its own. A fractional accumulator divides the system clock into exactly `2**FINE_W` fine steps per second. Each time the fine count wraps, the coarse seconds advance by one.

A one-cycle tick input marks the start of a new second. The tick zeroes the fine count and restarts the divider. It also either advances the coarse seconds or applies a coarse value that software wrote earlier. The most significant coarse bit is a loss-of-sync flag. It is raised when `DESYNC_SECS` whole seconds pass with no tick, and a tick lowers it again.

Software reaches the block through an APB slave. It can queue a new coarse value, pulse a soft-reset output and read the live time.

Top module: `onboard_time_keeper`

## Requirements
- R1: While `rstN` is low (asynchronous, active low), both time outputs, the soft-reset output and the read data are zero.
- R2: Without ticks, the divider adds `2**FINE_W` to an accumulator each cycle. Whenever the sum reaches `CLK_HZ`, the fine count advances by one and the accumulator keeps the remainder. When the fine count wraps from all ones to zero, coarse bits 30:0 increase by one in that same cycle, so fine time is zero in any cycle in which the coarse word changes.
- R3: A tick in cycle n gives a fine count of zero and an accumulator of zero in cycle n+1. Without a queued load, coarse bits 30:0 increase by one and bit 31 is cleared. A tick takes priority over a fine step in the same cycle.
- R4: The loss-of-sync flag (coarse bit 31) is set together with the fine wrap that completes the `DESYNC_SECS`-th second since reset or since the last tick. It then stays set until a tick.
- R5: An APB write at offset 0x04 stores the written word as a queued coarse value and does not change the outputs. The next tick loads all 32 bits, bit 31 included, into the coarse word and zeroes the fine count. A write in the same cycle as the tick stays queued for the following tick.
- R6: An APB write at offset 0x00 with bit 1 set drives `softResetOut` high for exactly the one cycle after the write. The same write with bit 1 clear gives no pulse.
- R7: An APB read at offset 0x08 returns the coarse word, and a read at 0x0C returns the fine count zero-extended. Any other offset returns zero.
- R8: The time formed by coarse bits 30:0 over the fine count never decreases from one cycle to the next, except in the cycle after a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickIn | input | 1 | One-cycle time tick, synchronous to clk |
| apbSel | input | 1 | APB select |
| apbEnable | input | 1 | APB access phase |
| apbWrite | input | 1 | APB write (1) or read (0) |
| apbAddr | input | ADDR_W | APB byte offset |
| apbWdata | input | 32 | APB write data |
| apbRdata | output | 32 | APB read data, combinational |
| timeCoarse | output | 32 | Coarse seconds; bit 31 is the loss-of-sync flag |
| timeFine | output | FINE_W | Fine sub-second count |
| softResetOut | output | 1 | One-cycle soft reset pulse |

## Verification
The bench builds the block with `CLK_HZ=20`, `FINE_W=3` and `DESYNC_SECS=3`. A second is then 20 cycles of 8 fine steps, with a non-integer 2.5-cycle step spacing. This puts every fine wrap, desync flag event and tick/wrap collision within a few thousand cycles. A cycle-accurate arithmetic reference is compared against the outputs on every cycle. Meanwhile ticks and queued loads are placed at pseudo-random offsets, covering ticks on wrap cycles, ticks racing a load write, and long tick-free stretches.

// File: rtl/otk_pkg.sv
package otk_pkg;

  // Strobes from the sync control to the time datapath
  typedef struct packed {
    logic fineStep;   // advance the fine count by one
    logic resync;     // tick: zero fine, advance or load coarse
    logic applyLoad;  // with resync: take the queued coarse word
    logic setDesync;  // with the current wrap: raise the flag
  } timeStrobes_t;

  localparam int OFF_CTRL   = 'h00;
  localparam int OFF_LOAD   = 'h04;
  localparam int OFF_COARSE = 'h08;
  localparam int OFF_FINE   = 'h0C;
  localparam int SWRST_BIT  = 1;

endpackage

// File: rtl/otk_apb_regs.sv
module otk_apb_regs
  import otk_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int COARSE_W = 32,
  parameter int FINE_W   = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tickIn,
  input  logic                apbSel,
  input  logic                apbEnable,
  input  logic                apbWrite,
  input  logic [ADDR_W-1:0]   apbAddr,
  input  logic [COARSE_W-1:0] apbWdata,
  output logic [COARSE_W-1:0] apbRdata,
  input  logic [COARSE_W-1:0] coarseQ,
  input  logic [FINE_W-1:0]   fineQ,
  output logic                pendValid,
  output logic [COARSE_W-1:0] pendWord,
  output logic                softResetOut
);

  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_LOAD   = ADDR_W'(OFF_LOAD);
  localparam logic [ADDR_W-1:0] A_COARSE = ADDR_W'(OFF_COARSE);
  localparam logic [ADDR_W-1:0] A_FINE   = ADDR_W'(OFF_FINE);

  logic wrEn, rdEn, wrLoad, wrCtrl;

  assign wrEn   = apbSel && apbEnable && apbWrite;
  assign rdEn   = apbSel && !apbWrite;
  assign wrLoad = wrEn && (apbAddr == A_LOAD);
  assign wrCtrl = wrEn && (apbAddr == A_CTRL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid    <= 1'b0;
      pendWord     <= '0;
      softResetOut <= 1'b0;
    end else begin
      softResetOut <= wrCtrl && apbWdata[SWRST_BIT];
      if (wrLoad) begin
        pendValid <= 1'b1;
        pendWord  <= apbWdata;
      end else if (tickIn) begin
        pendValid <= 1'b0;
      end
    end
  end

  always_comb begin
    apbRdata = '0;
    if (rdEn) begin
      if (apbAddr == A_COARSE)
        apbRdata = coarseQ;
      else if (apbAddr == A_FINE)
        apbRdata = {{(COARSE_W-FINE_W){1'b0}}, fineQ};
    end
  end

  AST_SWRST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    softResetOut |=> !softResetOut); // R6

  AST_TICK_CONSUMES_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (tickIn && !wrLoad) |=> !pendValid); // R5

endmodule

// File: rtl/otk_sync_ctrl.sv
module otk_sync_ctrl
  import otk_pkg::*;
#(
  parameter int CLK_HZ      = 25_000_000,
  parameter int FINE_W      = 16,
  parameter int DESYNC_SECS = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         tickIn,
  input  logic         pendValid,
  input  logic         secondDone,
  output timeStrobes_t strobes
);

  localparam int FINE_STEPS = 2 ** FINE_W;
  localparam int ACC_W      = $clog2(2 * CLK_HZ);
  localparam int SEC_W      = $clog2(DESYNC_SECS + 1);
  localparam logic [ACC_W-1:0] STEP_V = ACC_W'(FINE_STEPS);
  localparam logic [ACC_W-1:0] CLK_V  = ACC_W'(CLK_HZ);
  localparam logic [SEC_W-1:0] LIMIT  = SEC_W'(DESYNC_SECS);

  logic [ACC_W-1:0] accQ, accSum;
  logic             stepNow;
  logic [SEC_W-1:0] idleSecs;

  assign accSum  = accQ + STEP_V;
  assign stepNow = (accSum >= CLK_V);

  always_comb begin
    strobes.resync    = tickIn;
    strobes.applyLoad = tickIn && pendValid;
    strobes.fineStep  = stepNow && !tickIn;
    strobes.setDesync = secondDone && (idleSecs == LIMIT - 1'b1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ     <= '0;
      idleSecs <= '0;
    end else if (tickIn) begin
      accQ     <= '0;
      idleSecs <= '0;
    end else begin
      accQ <= stepNow ? (accSum - CLK_V) : accSum;
      if (secondDone && (idleSecs < LIMIT))
        idleSecs <= idleSecs + 1'b1;
    end
  end

  AST_IDLE_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    idleSecs <= LIMIT); // R4

  AST_ACC_BELOW_CLK: assert property (@(posedge clk) disable iff (!rstN)
    accQ < CLK_V); // R2

  AST_TICK_RESTARTS_DIV: assert property (@(posedge clk) disable iff (!rstN)
    tickIn |=> (accQ == '0) && (idleSecs == '0)); // R3

endmodule

// File: rtl/otk_timebase.sv
module otk_timebase
  import otk_pkg::*;
#(
  parameter int COARSE_W = 32,
  parameter int FINE_W   = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  timeStrobes_t        strobes,
  input  logic [COARSE_W-1:0] loadValue,
  output logic                secondDone,
  output logic [COARSE_W-1:0] coarseQ,
  output logic [FINE_W-1:0]   fineQ
);

  localparam int SEC_BITS = COARSE_W - 1;

  logic [SEC_BITS-1:0] secsNext;

  assign secondDone = strobes.fineStep && (fineQ == '1);
  assign secsNext   = coarseQ[SEC_BITS-1:0] + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coarseQ <= '0;
      fineQ   <= '0;
    end else if (strobes.resync) begin
      fineQ   <= '0;
      coarseQ <= strobes.applyLoad ? loadValue : {1'b0, secsNext};
    end else if (strobes.fineStep) begin
      fineQ <= fineQ + 1'b1;
      if (secondDone)
        coarseQ <= {coarseQ[COARSE_W-1] | strobes.setDesync, secsNext};
    end
  end

  AST_COARSE_MOVE_FINE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(coarseQ) |-> (fineQ == '0)); // R2

  AST_TICK_ZEROES_FINE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.resync |=> (fineQ == '0)); // R3

  AST_TICK_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.resync && !strobes.applyLoad) |=> !coarseQ[COARSE_W-1]); // R4

  AST_TIME_MONOTONIC: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobes.resync) |->
      ({coarseQ[SEC_BITS-1:0], fineQ} >= $past({coarseQ[SEC_BITS-1:0], fineQ}))); // R8

endmodule

// File: rtl/onboard_time_keeper.sv
module onboard_time_keeper
  import otk_pkg::*;
#(
  parameter int CLK_HZ      = 25_000_000,
  parameter int FINE_W      = 16,
  parameter int DESYNC_SECS = 4,
  parameter int ADDR_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickIn,
  input  logic              apbSel,
  input  logic              apbEnable,
  input  logic              apbWrite,
  input  logic [ADDR_W-1:0] apbAddr,
  input  logic [31:0]       apbWdata,
  output logic [31:0]       apbRdata,
  output logic [31:0]       timeCoarse,
  output logic [FINE_W-1:0] timeFine,
  output logic              softResetOut
);

  localparam int COARSE_W = 32;

  timeStrobes_t        strobes;
  logic                pendValid;
  logic [COARSE_W-1:0] pendWord;
  logic                secondDone;

  otk_apb_regs #(.ADDR_W(ADDR_W), .COARSE_W(COARSE_W), .FINE_W(FINE_W)) u_regs (
    .clk(clk), .rstN(rstN), .tickIn(tickIn),
    .apbSel(apbSel), .apbEnable(apbEnable), .apbWrite(apbWrite),
    .apbAddr(apbAddr), .apbWdata(apbWdata), .apbRdata(apbRdata),
    .coarseQ(timeCoarse), .fineQ(timeFine),
    .pendValid(pendValid), .pendWord(pendWord), .softResetOut(softResetOut)
  );

  otk_sync_ctrl #(.CLK_HZ(CLK_HZ), .FINE_W(FINE_W), .DESYNC_SECS(DESYNC_SECS)) u_ctrl (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .pendValid(pendValid),
    .secondDone(secondDone), .strobes(strobes)
  );

  otk_timebase #(.COARSE_W(COARSE_W), .FINE_W(FINE_W)) u_time (
    .clk(clk), .rstN(rstN), .strobes(strobes), .loadValue(pendWord),
    .secondDone(secondDone), .coarseQ(timeCoarse), .fineQ(timeFine)
  );

endmodule

// File: tb/sim_onboard_time_keeper.sv
`timescale 1ns/1ps
module sim_onboard_time_keeper;

  localparam int CLK_HZ = 20;
  localparam int FINE_W = 3;
  localparam int STEPS  = 8;
  localparam int LIM    = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickIn = 1'b0;
  logic        apbSel = 1'b0, apbEnable = 1'b0, apbWrite = 1'b0;
  logic [7:0]  apbAddr = '0;
  logic [31:0] apbWdata = '0;
  logic [31:0] apbRdata, timeCoarse;
  logic [2:0]  timeFine;
  logic        softResetOut;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  onboard_time_keeper #(.CLK_HZ(CLK_HZ), .FINE_W(FINE_W), .DESYNC_SECS(LIM), .ADDR_W(8)) u0 (
    .clk(clk), .rstN(rstN), .tickIn(tickIn),
    .apbSel(apbSel), .apbEnable(apbEnable), .apbWrite(apbWrite),
    .apbAddr(apbAddr), .apbWdata(apbWdata), .apbRdata(apbRdata),
    .timeCoarse(timeCoarse), .timeFine(timeFine), .softResetOut(softResetOut)
  );

  // Arithmetic reference built from the requirements
  logic [31:0] mCoarse, mPendW;
  logic [2:0]  mFine;
  int          mAcc, mSecs;
  logic        mPend, mSw, mLastTick;
  logic [33:0] prevTime;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCoarse <= '0; mFine <= '0; mAcc <= 0; mSecs <= 0;
      mPend <= 1'b0; mPendW <= '0; mSw <= 1'b0; mLastTick <= 1'b0;
    end else begin
      mSw <= apbSel && apbEnable && apbWrite && apbAddr == 8'h00 && apbWdata[1];
      mLastTick <= tickIn;
      if (apbSel && apbEnable && apbWrite && apbAddr == 8'h04) begin
        mPend <= 1'b1; mPendW <= apbWdata;
      end else if (tickIn) mPend <= 1'b0;
      if (tickIn) begin
        mFine <= '0; mAcc <= 0; mSecs <= 0;
        mCoarse <= mPend ? mPendW : {1'b0, mCoarse[30:0] + 31'd1};
      end else if (mAcc + STEPS >= CLK_HZ) begin
        mAcc <= mAcc + STEPS - CLK_HZ;
        mFine <= mFine + 3'd1;
        if (mFine == 3'd7) begin
          mCoarse <= {mCoarse[31] | (mSecs == LIM - 1), mCoarse[30:0] + 31'd1};
          if (mSecs < LIM) mSecs <= mSecs + 1;
        end
      end else mAcc <= mAcc + STEPS;
    end
  end

  // Every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      checks++;
      if (timeCoarse[30:0] !== mCoarse[30:0] || timeFine !== mFine) begin
        fails++;
        $display("FAIL R2/R3 time: got %h.%0d expected %h.%0d", timeCoarse, timeFine, mCoarse, mFine);
      end
      checks++;
      if (timeCoarse[31] !== mCoarse[31]) begin
        fails++;
        $display("FAIL R4 flag: got %0b expected %0b", timeCoarse[31], mCoarse[31]);
      end
      checks++;
      if (softResetOut !== mSw) begin
        fails++;
        $display("FAIL R6 softReset: got %0b expected %0b", softResetOut, mSw);
      end
      if (!mLastTick) begin
        checks++;
        if ({timeCoarse[30:0], timeFine} < prevTime) begin
          fails++;
          $display("FAIL R8 time decreased: got %h expected >= %h", {timeCoarse[30:0], timeFine}, prevTime);
        end
      end
      prevTime = {timeCoarse[30:0], timeFine};
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic apbWriteOp(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); apbSel = 1; apbWrite = 1; apbAddr = a; apbWdata = d; apbEnable = 0;
    @(negedge clk); apbEnable = 1;
    @(negedge clk); apbSel = 0; apbEnable = 0; apbWrite = 0; apbAddr = '0; apbWdata = '0;
  endtask

  task automatic apbReadCheck(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); apbSel = 1; apbWrite = 0; apbAddr = a; apbEnable = 0;
    @(negedge clk); apbEnable = 1; #1;
    check(tag, apbRdata, exp);
    @(negedge clk); apbSel = 0; apbEnable = 0; apbAddr = '0;
  endtask

  task automatic pulseTick();
    @(negedge clk); tickIn = 1;
    @(negedge clk); tickIn = 0;
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    repeat (2) @(negedge clk);
    // R1 reset state
    check("R1 coarse", timeCoarse, 32'h0);
    check("R1 fine", {29'b0, timeFine}, 32'h0);
    check("R1 softReset", {31'b0, softResetOut}, 32'h0);
    apbSel = 1; apbAddr = 8'h08; #1;
    check("R1 rdata", apbRdata, 32'h0);
    apbSel = 0; apbAddr = '0;
    @(negedge clk); rstN = 1;
    // R2: 40 cycles = 2 seconds
    repeat (40) @(posedge clk); @(negedge clk);
    check("R2 two seconds", timeCoarse, 32'h2);
    check("R2 fine zero", {29'b0, timeFine}, 32'h0);
    // R4: third second raises the flag
    repeat (20) @(posedge clk); @(negedge clk);
    check("R4 desync set", timeCoarse, 32'h8000_0003);
    // R3 tick clears flag, advances seconds
    repeat (7) @(negedge clk);
    pulseTick();
    check("R3 tick coarse", timeCoarse, 32'h4);
    check("R3 tick fine", {29'b0, timeFine}, 32'h0);
    // R5 queued load
    apbWriteOp(8'h04, 32'h8000_1234);
    check("R5 load held", timeCoarse, mCoarse);
    pulseTick();
    check("R5 load applied", timeCoarse, 32'h8000_1234);
    check("R5 load fine zero", {29'b0, timeFine}, 32'h0);
    // R6 soft reset
    apbWriteOp(8'h00, 32'h2);
    check("R6 pulse seen", {31'b0, mSw}, 32'h1);
    @(negedge clk);
    check("R6 pulse ends", {31'b0, softResetOut}, 32'h0);
    apbWriteOp(8'h00, 32'h1);
    check("R6 no pulse", {31'b0, softResetOut}, 32'h0);
    // R7 reads
    apbReadCheck(8'h08, mCoarse, "R7 coarse read");
    apbReadCheck(8'h0C, {29'b0, mFine}, "R7 fine read");
    apbReadCheck(8'h10, 32'h0, "R7 other read");
    apbReadCheck(8'h04, 32'h0, "R7 load read");
    // Random sweep of ticks, loads, and tick/write collisions
    for (int i = 0; i < 6000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[5:0] == 6'd7) begin
        apbWriteOp(8'h04, {lfsr[15], 15'b0, lfsr});
      end else if (lfsr[5:0] == 6'd9) begin
        @(negedge clk); apbSel = 1; apbWrite = 1; apbAddr = 8'h04; apbWdata = {16'b0, lfsr};
        @(negedge clk); apbEnable = 1; tickIn = 1;
        @(negedge clk); apbSel = 0; apbEnable = 0; apbWrite = 0; tickIn = 0;
      end else begin
        @(negedge clk);
        tickIn = (lfsr[9:4] == 6'd3) && (i < 4000);
      end
    end
    @(negedge clk); tickIn = 0;
    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule